// File: doc/BRIEF.md
# Banked Memory Mapper Register Decoder

This block sits on the cartridge side of an 8-bit CPU write bus. It watches CPU writes in the 0x8000–0xEFFF range and keeps a small set of bank registers up to date. From these registers it presents bank numbers to a combinational address lookup outside the block:

- one number for each of four 8 KB program windows, at 0x8000, 0xA000, 0xC000 and 0xE000;
- one number for each of eight 1 KB pattern windows, from 0x0000 to 0x1C00;
- a two-bit nametable mirroring select.

Two program windows trade roles under a mode bit. Each pattern bank register is filled by two separate nibble writes. Every register also answers at alias addresses, where address lines A2/A3 stand in for A0/A1. Program bank numbers are cut down to the number of installed 8 KB banks, which is set by a parameter.

Top module: `mmap_bank_ctrl`

## Requirements
- R1: After reset, the program windows read 0, 0, N-2 and N-1, where N is `PRG_BANKS`. All eight pattern banks read 0. The mirroring select reads 0 (vertical).
- R2: A write to 0x8000, 0x8001, 0x8002, 0x8003, 0x8004, 0x8008 or 0x800C loads the program select register. Only the low log2(N) bits of the data appear as a bank number.
- R3: A write to 0xA000, 0xA001, 0xA002, 0xA003, 0xA004, 0xA008 or 0xA00C loads the bank number of the 0xA000 window (`prg_bank_o[1]`), masked to log2(N) bits.
- R4: Data bit 1 of a write to 0x9001, 0x9003, 0x9004 or 0x900C sets the program mode. In mode 0, window 0 (0x8000) shows the select register and window 2 (0xC000) shows bank N-2. In mode 1, these two assignments swap.
- R5: Window 3 (0xE000) always shows bank N-1.
- R6: Data bits [1:0] of a write to 0x9000, 0x9002 or 0x9008 set `mirror_o`. The codes are: 0 vertical, 1 horizontal, 2 single-screen page A, 3 single-screen page B.
- R7: The eight pattern registers form pairs. Pair 0/1 is based at 0xB000, pair 2/3 at 0xC000, pair 4/5 at 0xD000 and pair 6/7 at 0xE000. Within a pair:
  - the even register's low nibble is written at base+0;
  - the even register's high nibble is written at base+2 or base+8;
  - the odd register's low nibble is written at base+1 or base+4;
  - the odd register's high nibble is written at base+3 or base+C.
  
  Each write replaces only the addressed nibble, taking it from data[3:0]. The other nibble keeps its value.
- R8: Writes to any other address change no output. This includes addresses below 0x8000, at or above 0xF000, with any of A11..A4 set, or with a low nibble outside {0,1,2,3,4,8,C}.
- R9: While the write strobe is low, no output changes, whatever the address and data are.
- R10: A write sampled on a rising clock edge shows at the outputs right after that edge. It is stable before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| prg_bank_o | output | 4 x log2(PRG_BANKS) | Bank number per 8 KB program window; index 0 is 0x8000, index 3 is 0xE000 |
| chr_bank_o | output | 8 x 8 | Bank number per 1 KB pattern window; index k is window k*0x400 |
| mirror_o | output | 2 | Nametable mirroring select |

## Verification
Every register sits one flop behind the bus. The bench drives a write on a falling edge. The write is sampled on the next rising edge, and every output is compared on the falling edge after that. This is half a cycle after the update, so no check races the clock. Strobe-low cycles and writes to invalid addresses are followed by a full comparison at the same point. This shows that nothing moved before the next stimulus. The bound assertions check the same one-cycle relation, using `$past` of the bus values.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

   localparam int NUM_PRG_WIN = 4;
   localparam int NUM_CHR_REG = 8;
   localparam int CHR_W       = 8;

   typedef enum logic [1:0] {
      MIR_VERT  = 2'd0,
      MIR_HORZ  = 2'd1,
      MIR_ONE_A = 2'd2,
      MIR_ONE_B = 2'd3
   } mirror_e;

   typedef struct packed {
      logic                   prg_sel;
      logic                   prg_a;
      logic                   mode;
      logic                   mirror;
      logic [NUM_CHR_REG-1:0] chr_lo;
      logic [NUM_CHR_REG-1:0] chr_hi;
   } mmap_we_t;

endpackage

// File: rtl/mmap_wr_decode.sv
module mmap_wr_decode
   import mmap_pkg::*;
(
   input  logic [15:0] addr,
   input  logic        wr,
   output mmap_we_t    we
);
   logic [3:0] lo;
   logic       slot_ok;
   logic       code_odd;
   logic       code_hi;
   logic [1:0] pair;

   always_comb begin
      lo       = addr[3:0];
      slot_ok  = wr && (addr[11:4] == 8'h00) && ((lo[3:2] == 2'b00) || (lo[1:0] == 2'b00));
      code_odd = lo[0] | lo[2];
      code_hi  = lo[1] | lo[3];
      pair     = 2'(addr[15:12] - 4'hB);
      we       = '0;
      if (slot_ok) begin
         unique case (addr[15:12])
            4'h8: we.prg_sel = 1'b1;
            4'h9: begin
               we.mode   = code_odd;
               we.mirror = !code_odd;
            end
            4'hA: we.prg_a = 1'b1;
            4'hB, 4'hC, 4'hD, 4'hE: begin
               we.chr_lo[{pair, code_odd}] = !code_hi;
               we.chr_hi[{pair, code_odd}] = code_hi;
            end
            default: we = '0;
         endcase
      end
   end
endmodule

// File: rtl/mmap_nibble_reg.sv
module mmap_nibble_reg
   import mmap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_lo,
   input  logic             we_hi,
   input  logic [3:0]       din,
   output logic [CHR_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else begin
         if (we_lo) q[3:0] <= din;
         if (we_hi) q[7:4] <= din;
      end
   end
endmodule

// File: rtl/mmap_prg_map.sv
module mmap_prg_map
   import mmap_pkg::*;
#(
   parameter  int PRG_BANKS = 16,
   localparam int PRG_BW    = $clog2(PRG_BANKS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  mmap_we_t                          we,
   input  logic [7:0]                        din,
   output logic [NUM_PRG_WIN-1:0][PRG_BW-1:0] bank_o
);
   localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);
   localparam logic [PRG_BW-1:0] PENU_BANK = PRG_BW'(PRG_BANKS - 2);

   logic [PRG_BW-1:0] sel_q;
   logic [PRG_BW-1:0] a_q;
   logic              mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         a_q    <= '0;
         mode_q <= 1'b0;
      end else begin
         if (we.prg_sel) sel_q  <= din[PRG_BW-1:0];
         if (we.prg_a)   a_q    <= din[PRG_BW-1:0];
         if (we.mode)    mode_q <= din[1];
      end
   end

   always_comb begin
      bank_o[0] = mode_q ? PENU_BANK : sel_q;
      bank_o[1] = a_q;
      bank_o[2] = mode_q ? sel_q : PENU_BANK;
      bank_o[3] = LAST_BANK;
   end
endmodule

// File: rtl/mmap_bank_ctrl.sv
module mmap_bank_ctrl
   import mmap_pkg::*;
#(
   parameter  int PRG_BANKS = 16,
   localparam int PRG_BW    = $clog2(PRG_BANKS)
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [15:0]                             cpu_addr,
   input  logic [7:0]                              cpu_data,
   input  logic                                    cpu_wr,
   output logic [NUM_PRG_WIN-1:0][PRG_BW-1:0]      prg_bank_o,
   output logic [NUM_CHR_REG-1:0][CHR_W-1:0]       chr_bank_o,
   output logic [1:0]                              mirror_o
);
   initial begin
      assert (PRG_BANKS >= 2 && PRG_BANKS <= 32)
         else $error("PRG_BANKS must lie in 2..32");
      assert ((PRG_BANKS & (PRG_BANKS - 1)) == 0)
         else $error("PRG_BANKS must be a power of two");
   end

   mmap_we_t we;
   mirror_e  mirror_q;

   mmap_wr_decode i_dec (
      .addr (cpu_addr),
      .wr   (cpu_wr),
      .we   (we)
   );

   mmap_prg_map #(.PRG_BANKS(PRG_BANKS)) i_prg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .din    (cpu_data),
      .bank_o (prg_bank_o)
   );

   for (genvar k = 0; k < NUM_CHR_REG; k++) begin : g_chr
      mmap_nibble_reg i_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we_lo (we.chr_lo[k]),
         .we_hi (we.chr_hi[k]),
         .din   (cpu_data[3:0]),
         .q     (chr_bank_o[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mirror_q <= MIR_VERT;
      else if (we.mirror)
         mirror_q <= mirror_e'(cpu_data[1:0]);
   end

   assign mirror_o = mirror_q;
endmodule

// File: rtl/mmap_bank_ctrl_chk.sv
module mmap_bank_ctrl_chk
   import mmap_pkg::*;
#(
   parameter  int PRG_BANKS = 16,
   localparam int PRG_BW    = $clog2(PRG_BANKS)
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [15:0]                        cpu_addr,
   input logic [7:0]                         cpu_data,
   input logic                               cpu_wr,
   input logic [NUM_PRG_WIN-1:0][PRG_BW-1:0] prg_bank_o,
   input logic [NUM_CHR_REG-1:0][CHR_W-1:0]  chr_bank_o,
   input logic [1:0]                         mirror_o
);
   localparam logic [PRG_BW-1:0] PENU = PRG_BW'(PRG_BANKS - 2);

   assert_penultimate_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prg_bank_o[0] == PENU) || (prg_bank_o[2] == PENU));

   assert_mirror_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == 16'h9000) |=> (mirror_o == $past(cpu_data[1:0])));

   assert_a_window_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == 16'hA008) |=> (prg_bank_o[1] == $past(cpu_data[PRG_BW-1:0])));

   assert_nibble_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == 16'hB000) |=>
         (chr_bank_o[0][3:0] == $past(cpu_data[3:0])) && $stable(chr_bank_o[0][7:4]));

   assert_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && (cpu_addr[15] == 1'b0 || cpu_addr[15:12] == 4'hF || cpu_addr[11:4] != 8'h00)) |=>
         ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

   assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));
endmodule

bind mmap_bank_ctrl mmap_bank_ctrl_chk #(.PRG_BANKS(PRG_BANKS)) i_chk (.*);

// File: tb/test_mmap_bank_ctrl.sv
module test_mmap_bank_ctrl;
   localparam int PRG_BANKS = 16;
   localparam int PRG_BW    = 4;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [15:0]            cpu_addr = '0;
   logic [7:0]             cpu_data = '0;
   logic                   cpu_wr = 1'b0;
   logic [3:0][PRG_BW-1:0] prg_bank_o;
   logic [7:0][7:0]        chr_bank_o;
   logic [1:0]             mirror_o;

   int checks = 0;
   int fails  = 0;

   logic [7:0] m_sel, m_a, m_mir;
   logic       m_mode;
   logic [7:0] m_chr [8];

   always #5 clk = ~clk;

   mmap_bank_ctrl #(.PRG_BANKS(PRG_BANKS)) i_mmap_bank_ctrl (.*);

   function automatic logic [PRG_BW-1:0] exp_win(input int w);
      logic [PRG_BW-1:0] s;
      s = PRG_BW'(m_sel % PRG_BANKS);
      case (w)
         0:       return m_mode ? PRG_BW'(PRG_BANKS - 2) : s;
         1:       return PRG_BW'(m_a % PRG_BANKS);
         2:       return m_mode ? s : PRG_BW'(PRG_BANKS - 2);
         default: return PRG_BW'(PRG_BANKS - 1);
      endcase
   endfunction

   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      int r;
      logic [11:0] off;
      off = a[11:0];
      case (a[15:12])
         4'h8: if (off inside {12'h0, 12'h1, 12'h2, 12'h3, 12'h4, 12'h8, 12'hC}) m_sel = d;
         4'hA: if (off inside {12'h0, 12'h1, 12'h2, 12'h3, 12'h4, 12'h8, 12'hC}) m_a = d;
         4'h9: begin
            if (off inside {12'h1, 12'h3, 12'h4, 12'hC}) m_mode = d[1];
            if (off inside {12'h0, 12'h2, 12'h8}) m_mir = {6'd0, d[1:0]};
         end
         4'hB, 4'hC, 4'hD, 4'hE: begin
            r = 2 * (int'(a[15:12]) - 11);
            if (off == 12'h0) m_chr[r][3:0] = d[3:0];
            if (off inside {12'h2, 12'h8}) m_chr[r][7:4] = d[3:0];
            if (off inside {12'h1, 12'h4}) m_chr[r+1][3:0] = d[3:0];
            if (off inside {12'h3, 12'hC}) m_chr[r+1][7:4] = d[3:0];
         end
         default: ;
      endcase
   endtask

   task automatic compare(input string req);
      checks++;
      for (int w = 0; w < 4; w++)
         if (prg_bank_o[w] !== exp_win(w)) begin
            fails++;
            $display("FAIL %s prg window %0d actual %0d expected %0d", req, w, prg_bank_o[w], exp_win(w));
         end
      for (int k = 0; k < 8; k++)
         if (chr_bank_o[k] !== m_chr[k]) begin
            fails++;
            $display("FAIL %s pattern reg %0d actual %h expected %h", req, k, chr_bank_o[k], m_chr[k]);
         end
      if (mirror_o !== m_mir[1:0]) begin
         fails++;
         $display("FAIL %s mirror actual %0d expected %0d", req, mirror_o, m_mir[1:0]);
      end
   endtask

   // Drive on a falling edge, sampled at the next rising edge (R10), compared one falling edge later.
   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      model_write(a, d);
      compare(req);
   endtask

   function automatic logic [15:0] pick_addr();
      logic [3:0] lows [7] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h8, 4'hC};
      if ($urandom_range(0, 7) == 0) return 16'($urandom);
      return {4'(8 + $urandom_range(0, 6)), 8'h00, lows[$urandom_range(0, 6)]};
   endfunction

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240724));
      m_sel = 0; m_a = 0; m_mir = 0; m_mode = 0;
      for (int k = 0; k < 8; k++) m_chr[k] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset");

      wr(16'h8000, 8'h1B, "R2 select masked");
      wr(16'h800C, 8'h07, "R2 select alias");
      wr(16'hA004, 8'hFD, "R3 A window masked");
      wr(16'h9004, 8'h02, "R4 mode 1 swap");
      wr(16'h8008, 8'h05, "R4 select in mode 1");
      wr(16'h9003, 8'hFD, "R4 back to mode 0");
      wr(16'h9008, 8'h03, "R6 single B");
      wr(16'h9002, 8'hF1, "R6 horizontal");
      wr(16'hB000, 8'hFA, "R7 even low");
      wr(16'hB008, 8'h35, "R7 even high alias");
      wr(16'hC004, 8'h09, "R7 odd low alias");
      wr(16'hC00C, 8'h0E, "R7 odd high alias");
      wr(16'hE003, 8'h06, "R7 reg 7 high");
      wr(16'hD002, 8'h0C, "R7 reg 4 high");
      wr(16'h8005, 8'h0F, "R8 bad low nibble");
      wr(16'h8010, 8'h0F, "R8 A4 set");
      wr(16'hF000, 8'h0F, "R8 above range");
      wr(16'h7003, 8'h0F, "R8 below range");
      wr(16'h9001, 8'h02, "R5 mode 1 last fixed");

      @(negedge clk);
      cpu_addr = 16'hB001; cpu_data = 8'h0F; cpu_wr = 1'b0;
      @(negedge clk);
      compare("R9 strobe low");

      for (int i = 0; i < 600; i++)
         wr(pick_addr(), 8'($urandom), "R10 random write");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule